// File: doc/BRIEF.md
# Unimplemented Floating-Point Opcode Trap Sequencer

This block takes over when the decoder finds a floating-point opcode that the hardware cannot execute. It stalls the trap until the pipeline is quiet. That means no earlier floating-point operation is still executing, no older exception is still waiting for service, and no earlier memory access is still outstanding. It then fetches the memory source operand when the instruction has one and sorts that operand into a data class. Last, it enters supervisor mode and pushes a stack frame that a software emulation routine later consumes.

A bus error can strike during the drain or during the operand fetch. In that case the block writes nothing and signals that the instruction must be restarted once the bus-error handler returns. The frame carries format code 2, which sets it apart from the format-0 frame of the F-line illegal-instruction trap that uses the same vector. One handler can therefore serve both causes.

Top module: `fp_unimp_trap_seq`

## Requirements
- R1: After `start_i` the block raises neither `opf_req_o` nor `sr_we_o` while any of `fp_busy_i`, `exc_pend_i` or `acc_busy_i` is high. It leaves the drain one cycle after all three are low.
- R2: If `has_mem_i` was set at start, the block holds exactly one operand read with `opf_addr_o` equal to the latched effective address. The read stays asserted and stable until `opf_ack_i` or `bus_err_i`.
- R3: If `has_mem_i` was clear, no operand read occurs, `op_class_o` reads 0 (none), and both effective-address words of the frame are zero.
- R4: A `bus_err_i` seen during the drain or the operand fetch produces a single-cycle `restart_o`. It writes no frame word and does not touch the status register.
- R5: The class codes for a 32-bit operand are 1 zero, 2 normal, 3 denormal (exponent 0, fraction nonzero), 4 infinity/NaN (exponent all ones) and 5 packed decimal (`packed_i` set, which overrides the other codes). The class is valid from the cycle after classification until the next accepted start.
- R6: A denormal or packed-decimal operand still leads to the same format-2 frame and `done_o`, and to no other outcome.
- R7: For one cycle before the first frame word, `sr_we_o` is high with `sr_o` equal to `sr_i` with bit 13 (supervisor) set and bits 15 and 14 (trace) cleared. The frame keeps the unmodified `sr_i` from that cycle.
- R8: The six 16-bit frame words go to `sp-2`, `sp-4` … `sp-12` (`sp` latched at start), in this order: EA[15:0], EA[31:16], format/offset word, PC[15:0], PC[31:16], saved SR.
- R9: The format/offset word is 4'h2 in bits 15:12 and the vector number times 4 in bits 11:0 (0x202C for vector 11).
- R10: While `wr_ready_i` is low, `wr_valid_o` stays high and the address and data do not change.
- R11: `done_o` pulses exactly in the cycle the sixth word is accepted, once per trap.
- R12: `start_i` is ignored while a trap is in progress; the frame carries only the first request's fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Unimplemented FP opcode detected |
| has_mem_i | input | 1 | Instruction has a memory source operand |
| packed_i | input | 1 | Operand is in packed-decimal format |
| ea_i | input | 32 | Calculated effective address |
| pc_i | input | 32 | PC of the instruction |
| sp_i | input | 32 | Supervisor stack pointer before the push |
| sr_i | input | 16 | Current status register |
| fp_busy_i | input | 1 | Earlier FP instructions still executing |
| exc_pend_i | input | 1 | Earlier exception awaiting service |
| acc_busy_i | input | 1 | Earlier memory access still in flight |
| bus_err_i | input | 1 | Bus error on an in-flight or operand access |
| opf_req_o | output | 1 | Operand read request |
| opf_addr_o | output | 32 | Operand read address |
| opf_ack_i | input | 1 | Operand read complete |
| opf_data_i | input | 32 | Operand read data |
| sr_we_o | output | 1 | Status register write strobe |
| sr_o | output | 16 | New status register value |
| wr_valid_o | output | 1 | Frame word write valid |
| wr_addr_o | output | 32 | Frame word byte address |
| wr_data_o | output | 16 | Frame word |
| wr_ready_i | input | 1 | Frame word accepted |
| done_o | output | 1 | Last frame word accepted |
| restart_o | output | 1 | Instruction must be restarted |
| op_class_o | output | 3 | Operand class code |

## Verification
The bench releases the pending-FP, pending-exception and in-flight signals at different times. A design that left the drain early would issue the operand read or the status write too soon. Bus errors are injected both during the drain and with the operand acknowledge; a faulty design would push a partial frame or raise supervisor mode on a restarted instruction. Denormal, packed, zero and infinity operands are run with write-port stalls and a second start request mid-trap. These runs expose a frame that changes format for unsupported types, data that moves while stalled, a done pulse on the wrong word, or fields overwritten by the ignored request.

// File: rtl/fut_pkg.sv
package fut_pkg;
   localparam int SR_W       = 16;
   localparam int SR_S_BIT   = 13;
   localparam int SR_T0_BIT  = 14;
   localparam int SR_T1_BIT  = 15;
   localparam logic [3:0] FMT_UNIMP = 4'h2;

   typedef enum logic [2:0] {
      ST_IDLE, ST_DRAIN, ST_FETCH, ST_CLASS, ST_ENTER, ST_PUSH, ST_RESTART
   } fut_state_e;

   typedef enum logic [2:0] {
      CLS_NONE   = 3'd0,
      CLS_ZERO   = 3'd1,
      CLS_NORM   = 3'd2,
      CLS_DENORM = 3'd3,
      CLS_INFNAN = 3'd4,
      CLS_PACKED = 3'd5
   } fut_class_e;
endpackage

// File: rtl/fut_classify.sv
module fut_classify
   import fut_pkg::*;
#(
   parameter int OPW = 32
) (
   input  logic [OPW-1:0] opd_i,
   input  logic           packed_i,
   output fut_class_e     cls_o
);
   localparam int EXP_W  = (OPW == 64) ? 11 : 8;
   localparam int FRAC_W = OPW - 1 - EXP_W;

   if (OPW != 32 && OPW != 64) begin : g_bad_opw
      $error("fut_classify: OPW must be 32 or 64");
   end

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;

   if (OPW == 64) begin : g_dbl
      assign exp_f  = opd_i[62:52];
      assign frac_f = opd_i[51:0];
   end else begin : g_sgl
      assign exp_f  = opd_i[30:23];
      assign frac_f = opd_i[22:0];
   end

   always_comb begin
      if (packed_i)
         cls_o = CLS_PACKED;
      else if (exp_f == '0)
         cls_o = (frac_f == '0) ? CLS_ZERO : CLS_DENORM;
      else if (exp_f == '1)
         cls_o = CLS_INFNAN;
      else
         cls_o = CLS_NORM;
   end
endmodule

// File: rtl/fut_frame_push.sv
module fut_frame_push
   import fut_pkg::*;
#(
   parameter int AW      = 32,
   parameter int DW      = 16,
   parameter int VEC_NUM = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic          active_i,
   input  logic [AW-1:0] sp_i,
   input  logic [AW-1:0] pc_i,
   input  logic [AW-1:0] ea_i,
   input  logic [SR_W-1:0] sr_i,
   input  logic          wr_ready_i,
   output logic          wr_valid_o,
   output logic [AW-1:0] wr_addr_o,
   output logic [DW-1:0] wr_data_o,
   output logic          last_o
);
   localparam int PCW = AW / DW;
   localparam int NW  = 2 * PCW + 2;
   localparam int FW  = NW * DW;
   localparam int WB  = DW / 8;
   localparam int IW  = $clog2(NW);
   localparam logic [DW-1:0] FMT_WORD = DW'({FMT_UNIMP, 12'(VEC_NUM * 4)});

   if (DW != 16) begin : g_bad_dw
      $error("fut_frame_push: frame word layout needs DW == 16");
   end
   if (AW % DW != 0) begin : g_bad_aw
      $error("fut_frame_push: AW must be a multiple of DW");
   end
   if (VEC_NUM < 0 || VEC_NUM > 255) begin : g_bad_vec
      $error("fut_frame_push: VEC_NUM out of range");
   end

   logic [FW-1:0] frame_q;
   logic [IW-1:0] idx_q;
   logic [AW-1:0] addr_q;
   logic          accept;

   assign accept     = active_i && wr_ready_i;
   assign wr_valid_o = active_i;
   assign wr_addr_o  = addr_q;
   assign wr_data_o  = frame_q[DW-1:0];
   assign last_o     = accept && (idx_q == IW'(NW - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_q <= '0;
         idx_q   <= '0;
         addr_q  <= '0;
      end else if (load_i) begin
         frame_q <= {DW'(sr_i), pc_i, FMT_WORD, ea_i};
         idx_q   <= '0;
         addr_q  <= sp_i - AW'(WB);
      end else if (accept) begin
         frame_q <= frame_q >> DW;
         idx_q   <= idx_q + 1'b1;
         addr_q  <= addr_q - AW'(WB);
      end
   end

   a_r10_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

   a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !last_o) |=> (wr_valid_o && wr_addr_o == $past(wr_addr_o) - AW'(WB)));

   a_r11_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |=> !wr_valid_o);
endmodule

// File: rtl/fut_ctrl.sv
module fut_ctrl
   import fut_pkg::*;
#(
   parameter int AW  = 32,
   parameter int OPW = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  logic           has_mem_i,
   input  logic           packed_i,
   input  logic [AW-1:0]  ea_i,
   input  logic [AW-1:0]  pc_i,
   input  logic [AW-1:0]  sp_i,
   input  logic           fp_busy_i,
   input  logic           exc_pend_i,
   input  logic           acc_busy_i,
   input  logic           bus_err_i,
   input  logic           opf_ack_i,
   input  logic [OPW-1:0] opf_data_i,
   input  fut_class_e     cls_i,
   input  logic           push_last_i,
   output fut_state_e     state_o,
   output logic [AW-1:0]  ea_o,
   output logic [AW-1:0]  pc_o,
   output logic [AW-1:0]  sp_o,
   output logic [OPW-1:0] opd_o,
   output logic           packed_o,
   output fut_class_e     cls_o
);
   fut_state_e     st_q;
   logic           mem_q;
   logic           pk_q;
   logic [AW-1:0]  ea_q;
   logic [AW-1:0]  pc_q;
   logic [AW-1:0]  sp_q;
   logic [OPW-1:0] opd_q;
   fut_class_e     cls_q;
   logic           quiet;

   assign quiet = !fp_busy_i && !exc_pend_i && !acc_busy_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         mem_q <= 1'b0;
         pk_q  <= 1'b0;
         ea_q  <= '0;
         pc_q  <= '0;
         sp_q  <= '0;
         opd_q <= '0;
         cls_q <= CLS_NONE;
      end else begin
         unique case (st_q)
            ST_IDLE: if (start_i) begin
               st_q  <= ST_DRAIN;
               mem_q <= has_mem_i;
               pk_q  <= packed_i;
               ea_q  <= has_mem_i ? ea_i : '0;
               pc_q  <= pc_i;
               sp_q  <= sp_i;
               opd_q <= '0;
               cls_q <= CLS_NONE;
            end
            ST_DRAIN: begin
               if (bus_err_i)  st_q <= ST_RESTART;
               else if (quiet) st_q <= mem_q ? ST_FETCH : ST_ENTER;
            end
            ST_FETCH: begin
               if (bus_err_i) st_q <= ST_RESTART;
               else if (opf_ack_i) begin
                  opd_q <= opf_data_i;
                  st_q  <= ST_CLASS;
               end
            end
            ST_CLASS: begin
               cls_q <= cls_i;
               st_q  <= ST_ENTER;
            end
            ST_ENTER:   st_q <= ST_PUSH;
            ST_PUSH:    if (push_last_i) st_q <= ST_IDLE;
            ST_RESTART: st_q <= ST_IDLE;
            default:    st_q <= ST_IDLE;
         endcase
      end
   end

   assign state_o  = st_q;
   assign ea_o     = ea_q;
   assign pc_o     = pc_q;
   assign sp_o     = sp_q;
   assign opd_o    = opd_q;
   assign packed_o = pk_q;
   assign cls_o    = cls_q;

   a_r1_drain_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DRAIN && !quiet) |=> (st_q == ST_DRAIN || st_q == ST_RESTART));

   a_r2_fetch_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FETCH && !opf_ack_i && !bus_err_i) |=> (st_q == ST_FETCH && $stable(ea_q)));

   a_r4_restart_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RESTART) |=> (st_q == ST_IDLE));

   a_r12_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE && start_i) |=> ($stable(ea_q) && $stable(pc_q) && $stable(sp_q)));
endmodule

// File: rtl/fp_unimp_trap_seq.sv
module fp_unimp_trap_seq
   import fut_pkg::*;
#(
   parameter int AW      = 32,
   parameter int DW      = 16,
   parameter int OPW     = 32,
   parameter int VEC_NUM = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             has_mem_i,
   input  logic             packed_i,
   input  logic [AW-1:0]    ea_i,
   input  logic [AW-1:0]    pc_i,
   input  logic [AW-1:0]    sp_i,
   input  logic [SR_W-1:0]  sr_i,
   input  logic             fp_busy_i,
   input  logic             exc_pend_i,
   input  logic             acc_busy_i,
   input  logic             bus_err_i,
   output logic             opf_req_o,
   output logic [AW-1:0]    opf_addr_o,
   input  logic             opf_ack_i,
   input  logic [OPW-1:0]   opf_data_i,
   output logic             sr_we_o,
   output logic [SR_W-1:0]  sr_o,
   output logic             wr_valid_o,
   output logic [AW-1:0]    wr_addr_o,
   output logic [DW-1:0]    wr_data_o,
   input  logic             wr_ready_i,
   output logic             done_o,
   output logic             restart_o,
   output logic [2:0]       op_class_o
);
   localparam logic [SR_W-1:0] SR_SET = SR_W'(1) << SR_S_BIT;
   localparam logic [SR_W-1:0] SR_CLR = (SR_W'(1) << SR_T1_BIT) | (SR_W'(1) << SR_T0_BIT);

   fut_state_e     st;
   fut_class_e     cls_comb;
   fut_class_e     cls_reg;
   logic [AW-1:0]  ea_l, pc_l, sp_l;
   logic [OPW-1:0] opd_l;
   logic           pk_l;
   logic           last;

   fut_ctrl #(.AW(AW), .OPW(OPW)) u_ctrl (
      .clk, .rst_n, .start_i, .has_mem_i, .packed_i, .ea_i, .pc_i, .sp_i,
      .fp_busy_i, .exc_pend_i, .acc_busy_i, .bus_err_i, .opf_ack_i, .opf_data_i,
      .cls_i(cls_comb), .push_last_i(last), .state_o(st), .ea_o(ea_l),
      .pc_o(pc_l), .sp_o(sp_l), .opd_o(opd_l), .packed_o(pk_l), .cls_o(cls_reg)
   );

   fut_classify #(.OPW(OPW)) u_cls (
      .opd_i(opd_l), .packed_i(pk_l), .cls_o(cls_comb)
   );

   fut_frame_push #(.AW(AW), .DW(DW), .VEC_NUM(VEC_NUM)) u_push (
      .clk, .rst_n, .load_i(st == ST_ENTER), .active_i(st == ST_PUSH),
      .sp_i(sp_l), .pc_i(pc_l), .ea_i(ea_l), .sr_i(sr_i), .wr_ready_i,
      .wr_valid_o, .wr_addr_o, .wr_data_o, .last_o(last)
   );

   assign opf_req_o  = (st == ST_FETCH);
   assign opf_addr_o = ea_l;
   assign sr_we_o    = (st == ST_ENTER);
   assign sr_o       = (sr_i | SR_SET) & ~SR_CLR;
   assign restart_o  = (st == ST_RESTART);
   assign done_o     = last;
   assign op_class_o = cls_reg;

   a_r4_restart_clean: assert property (@(posedge clk) disable iff (!rst_n)
      restart_o |-> (!wr_valid_o && !sr_we_o && !opf_req_o));

   a_r7_sr_then_push: assert property (@(posedge clk) disable iff (!rst_n)
      sr_we_o |=> (wr_valid_o && !sr_we_o));

   a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
endmodule

// File: tb/fp_unimp_trap_seq_tb.sv
module fp_unimp_trap_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0, has_mem_i = 1'b0, packed_i = 1'b0;
   logic [31:0] ea_i = '0, pc_i = '0, sp_i = '0;
   logic [15:0] sr_i = '0;
   logic        fp_busy_i = 1'b0, exc_pend_i = 1'b0, acc_busy_i = 1'b0;
   logic        be_drain = 1'b0, be_fetch = 1'b0, bus_err_i;
   logic        opf_req_o, opf_ack_i = 1'b0;
   logic [31:0] opf_addr_o, opf_data_i = '0;
   logic        sr_we_o, wr_valid_o, wr_ready_i = 1'b1, done_o, restart_o;
   logic [15:0] sr_o, wr_data_o;
   logic [31:0] wr_addr_o;
   logic [2:0]  op_class_o;

   assign bus_err_i = be_drain | be_fetch;

   always #10 clk = ~clk;

   fp_unimp_trap_seq dut_i (
      .clk, .rst_n, .start_i, .has_mem_i, .packed_i, .ea_i, .pc_i, .sp_i, .sr_i,
      .fp_busy_i, .exc_pend_i, .acc_busy_i, .bus_err_i, .opf_req_o, .opf_addr_o,
      .opf_ack_i, .opf_data_i, .sr_we_o, .sr_o, .wr_valid_o, .wr_addr_o,
      .wr_data_o, .wr_ready_i, .done_o, .restart_o, .op_class_o
   );

   int checks = 0, fails = 0, cyc = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // behavioural reference
   int          m_ph = 0;   // 0 idle 1 drain 2 fetch 3 class 4 enter 5 push 6 restart
   logic        m_mem, m_pk;
   logic [31:0] m_ea, m_pc, m_sp, m_opd, m_addr;
   int          m_cls = 0, m_traps = 0;
   logic [15:0] m_fq[$];

   function automatic int classify(input logic [31:0] v, input logic pk);
      if (pk) return 5;
      if (v[30:23] == 8'hFF) return 4;
      if (v[30:23] == 8'h00) return (v[22:0] == 0) ? 1 : 3;
      return 2;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_cls = 0; m_fq.delete();
      end else begin
         case (m_ph)
            0: if (start_i) begin
               m_ph = 1; m_mem = has_mem_i; m_pk = packed_i;
               m_ea = has_mem_i ? ea_i : 32'h0; m_pc = pc_i; m_sp = sp_i; m_cls = 0;
            end
            1: if (bus_err_i) m_ph = 6;
               else if (!fp_busy_i && !exc_pend_i && !acc_busy_i) m_ph = m_mem ? 2 : 4;
            2: if (bus_err_i) m_ph = 6;
               else if (opf_ack_i) begin m_opd = opf_data_i; m_ph = 3; end
            3: begin m_cls = classify(m_opd, m_pk); m_ph = 4; end
            4: begin
               m_fq.delete();
               m_fq.push_back(m_ea[15:0]);  m_fq.push_back(m_ea[31:16]);
               m_fq.push_back(16'h2000 | 16'(11 * 4));
               m_fq.push_back(m_pc[15:0]);  m_fq.push_back(m_pc[31:16]);
               m_fq.push_back(sr_i);
               m_addr = m_sp - 2; m_ph = 5;
            end
            5: if (wr_ready_i) begin
               void'(m_fq.pop_front()); m_addr = m_addr - 2;
               if (m_fq.size() == 0) begin m_ph = 0; m_traps++; end
            end
            default: m_ph = 0;
         endcase
      end
   end

   // observed frame, compare every clock
   logic [15:0] obs[$];
   int          done_seen = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R1/R2 opf_req", opf_req_o, m_ph == 2);
         if (m_ph == 2) chk("R2 opf_addr", opf_addr_o, m_ea);
         chk("R7 sr_we", sr_we_o, m_ph == 4);
         if (m_ph == 4) chk("R7 sr_o", sr_o, (sr_i | 16'h2000) & 16'h3FFF);
         chk("R4 restart", restart_o, m_ph == 6);
         chk("R8/R10 wr_valid", wr_valid_o, m_ph == 5);
         if (m_ph == 5) begin
            chk("R8 wr_addr", wr_addr_o, m_addr);
            chk("R8/R9 wr_data", wr_data_o, m_fq[0]);
            if (wr_ready_i) obs.push_back(wr_data_o);
         end
         chk("R11 done", done_o, m_ph == 5 && wr_ready_i && m_fq.size() == 1);
         if (done_o) done_seen++;
         chk("R5 class", op_class_o, m_cls);
      end
   end

   // operand responder and write-port stall pattern
   int   ack_dly = 0, fcnt = 0;
   logic err_fetch = 1'b0, stall_en = 1'b0;

   always @(posedge clk) begin
      #1;
      cyc++;
      if (cyc > 100000) begin
         fails++; checks++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
      wr_ready_i = stall_en ? ((cyc % 3) != 1) : 1'b1;
      if (opf_req_o) begin
         opf_ack_i = (fcnt == ack_dly);
         be_fetch  = err_fetch && (fcnt == ack_dly);
         fcnt++;
      end else begin
         opf_ack_i = 1'b0; be_fetch = 1'b0; fcnt = 0;
      end
   end

   task automatic run_trap(input logic mem, input logic [31:0] ea, input logic [31:0] pc,
                           input logic [31:0] sp, input logic [15:0] sr, input logic [31:0] opd,
                           input logic pk, input int nfp, input int nexc, input int dly,
                           input logic efetch, input logic edrain, input logic stall,
                           input logic ghost);
      @(posedge clk); #2;
      obs.delete();
      has_mem_i = mem; ea_i = ea; pc_i = pc; sp_i = sp; sr_i = sr; packed_i = pk;
      opf_data_i = opd; ack_dly = dly; err_fetch = efetch; stall_en = stall;
      fp_busy_i = nfp > 0; exc_pend_i = nexc > 0; acc_busy_i = edrain;
      start_i = 1'b1;
      @(posedge clk); #2;
      start_i = 1'b0;
      for (int k = 1; k < 2000; k++) begin
         fp_busy_i  = k < nfp;
         exc_pend_i = k < nexc;
         acc_busy_i = edrain && k <= 2;
         be_drain   = edrain && k == 2;
         if (ghost && k == 4) begin
            start_i = 1'b1; ea_i = 32'hDEAD0000; pc_i = 32'hBAD00000; sp_i = 32'h100;
         end else start_i = 1'b0;
         if (m_ph == 0) break;
         @(posedge clk); #2;
      end
      be_drain = 1'b0; start_i = 1'b0; stall_en = 1'b0; err_fetch = 1'b0;
      fp_busy_i = 1'b0; exc_pend_i = 1'b0; acc_busy_i = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2;
      chk("R1 reset opf_req", opf_req_o, 0);
      chk("R4 reset restart", restart_o, 0);
      chk("R11 reset done", done_o, 0);
      chk("R5 reset class", op_class_o, 0);
      rst_n = 1'b1;

      // normal operand, quiet pipeline
      run_trap(1, 32'h0000_8000, 32'h0001_0040, 32'h0000_2000, 16'h0700, 32'h3F80_0000,
               0, 0, 0, 1, 0, 0, 0, 0);
      chk("R9 fmt word", obs.size() > 2 ? obs[2] : 16'hXXXX, 16'h202C);
      // drain with staggered busy signals, trace bits set
      run_trap(1, 32'h1234_5678, 32'hCAFE_0010, 32'h0000_4000, 16'hC71F, 32'h4049_0FDB,
               0, 4, 6, 0, 0, 0, 0, 0);
      chk("R7 saved sr", obs.size() == 6 ? obs[5] : 16'hXXXX, 16'hC71F);
      // no memory operand
      run_trap(0, 32'h5555_AAAA, 32'h0000_0100, 32'h0000_3000, 16'h0000, 32'h0,
               0, 2, 0, 0, 0, 0, 0, 0);
      chk("R3 ea low zero", obs.size() == 6 ? obs[0] : 16'hXXXX, 16'h0000);
      chk("R3 ea high zero", obs.size() == 6 ? obs[1] : 16'hXXXX, 16'h0000);
      chk("R3 class none", op_class_o, 0);
      // denormal operand
      run_trap(1, 32'h0000_0800, 32'h0000_0200, 32'h0000_5000, 16'h2000, 32'h0000_0001,
               0, 0, 0, 2, 0, 0, 0, 0);
      chk("R6 denorm frame fmt", obs.size() == 6 ? obs[2] : 16'hXXXX, 16'h202C);
      chk("R5 denorm class", op_class_o, 3);
      // packed-decimal operand, stalled writes
      run_trap(1, 32'h0000_0C00, 32'h0000_0300, 32'h0000_6000, 16'h0404, 32'h3F80_0000,
               1, 0, 0, 0, 0, 0, 1, 0);
      chk("R6 packed frame words", obs.size(), 6);
      chk("R10 stalled words", obs.size() == 6 ? obs[3] : 16'hXXXX, 16'h0300);
      // zero and infinity
      run_trap(1, 32'h0000_1000, 32'h0000_0400, 32'h0000_7000, 16'h0000, 32'h8000_0000,
               0, 0, 0, 0, 0, 0, 0, 0);
      chk("R5 zero class", op_class_o, 1);
      run_trap(1, 32'h0000_1004, 32'h0000_0404, 32'h0000_7000, 16'h0000, 32'h7F80_0000,
               0, 0, 0, 0, 0, 0, 1, 0);
      chk("R5 inf class", op_class_o, 4);
      // bus error on operand fetch
      run_trap(1, 32'h0000_2000, 32'h0000_0500, 32'h0000_8000, 16'h0000, 32'h3F80_0000,
               0, 0, 0, 1, 1, 0, 0, 0);
      chk("R4 fetch error no frame", obs.size(), 0);
      // bus error on in-flight access during drain
      run_trap(1, 32'h0000_2004, 32'h0000_0504, 32'h0000_8000, 16'h0000, 32'h3F80_0000,
               0, 0, 0, 0, 0, 1, 0, 0);
      chk("R4 drain error no frame", obs.size(), 0);
      // second start while busy
      run_trap(1, 32'h0000_9ABC, 32'h0000_0600, 32'h0000_9000, 16'h0000, 32'h4000_0000,
               0, 3, 0, 1, 0, 0, 1, 1);
      chk("R12 ea kept", obs.size() == 6 ? obs[0] : 16'hXXXX, 16'h9ABC);
      chk("R12 pc kept", obs.size() == 6 ? obs[3] : 16'hXXXX, 16'h0600);

      repeat (3) @(posedge clk);
      #2;
      chk("R11 done count", done_seen, m_traps);
      chk("R11 trap count", m_traps, 8);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule